// File: doc/BRIEF.md
# Instruction Stream Buffer Prefetcher

This block sits between an instruction cache and the next level of memory. It keeps a single stream-buffer slot holding one line address and, once it has arrived, that line's data. When the cache reports a miss to line `i` and the slot does not hold `i`, the block asks memory for line `i` and then for line `i+1`. Line `i` goes to the cache as a fill. Line `i+1` waits in the slot.

If a later miss names the line in the slot, the block refills the cache from the slot and does not go to memory for that line. It then requests the next sequential line into the slot. When the slotted line is still in flight, the fill waits for that response instead of issuing a second request. A miss to any other line discards the slot and restarts the sequence from the new address.

Memory responses carry back the line address of their request, so responses can be matched to what the block is waiting for. The cache accepts a fill on every cycle it is offered. The block handles one miss at a time.

Top module: `istream_prefetch`

## Requirements
- R1: After synchronous reset, `miss_ready` is 1 and both `fill_valid` and `mem_req_valid` are 0.
- R2: A miss to line `i` that the slot does not hold produces exactly two memory requests: first line `i`, then line `i+1`.
- R3: Every accepted miss produces exactly one fill carrying the missed line and its memory data. When the fill comes from memory, it appears one cycle after the response that carries that line.
- R4: A response for the prefetched line never produces a fill unless a miss asks for that line.
- R5: A miss to a line that the slot already holds with data is filled from the slot in the cycle after the miss is accepted. It sends no request for that line to memory, and the only request it sends is for the following line.
- R6: A miss to a line whose prefetch is still outstanding sends no duplicate request. It is filled one cycle after that line's response arrives, and it then requests the following line.
- R7: A miss that does not match the slot discards the slot. A late response for the discarded line is ignored, so a later miss to that line goes to memory again.
- R8: Line addresses wrap modulo 2^LINE_AW: the line after the highest address is line 0.
- R9: `miss_ready` drops in the cycle after a miss is accepted. It stays low until that miss's fill and its prefetch request have both been issued.
- R10: Once `mem_req_valid` is high, it stays high with an unchanged `mem_req_line` until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Block can accept a miss |
| miss_line | input | LINE_AW | Line address of the miss |
| fill_valid | output | 1 | One-cycle fill to the cache |
| fill_line | output | LINE_AW | Line address of the fill |
| fill_data | output | LINE_W | Line data of the fill |
| mem_req_valid | output | 1 | Request to memory is pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_AW | Requested line address |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_line | input | LINE_AW | Line address echoed with the response |
| mem_rsp_data | input | LINE_W | Response data |

## Verification
The bench sweeps memory latency from one to six cycles under three request-acceptance patterns, so that a repeated miss finds the prefetched line either already stored or still in flight. A design that lost a response arriving in the same cycle as a matching miss would hang in its wait state, and one that re-requested an outstanding line would show an extra request. Sequences that repeat a line after its successor has been prefetched, or that jump away and come back, catch a slot that is not flushed or that captures a stale response. The pair 63, 0 catches an address increment that does not wrap.

// File: rtl/istream_pkg.sv
package istream_pkg;

    localparam int DEF_LINE_AW = 8;
    localparam int DEF_LINE_W  = 32;

    // controller states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQ_DEM  = 3'd1,
        ST_REQ_PF   = 3'd2,
        ST_WAIT_DEM = 3'd3,
        ST_WAIT_BUF = 3'd4
    } isb_state_e;

    // which source feeds the registered fill
    typedef enum logic [1:0] {
        FSRC_NONE = 2'd0,
        FSRC_BUF  = 2'd1,
        FSRC_RSP  = 2'd2
    } fill_src_e;

endpackage

// File: rtl/istream_entry.sv
module istream_entry
    import istream_pkg::*;
#(
    parameter int LINE_AW = DEF_LINE_AW,
    parameter int LINE_W  = DEF_LINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINE_AW-1:0] probe_line,
    input  logic               alloc,
    input  logic [LINE_AW-1:0] alloc_line,
    input  logic               drop,
    input  logic               rsp_valid,
    input  logic [LINE_AW-1:0] rsp_line,
    input  logic [LINE_W-1:0]  rsp_data,
    output logic               hit_ready,
    output logic               hit_wait,
    output logic               catch_now,
    output logic [LINE_W-1:0]  held_data
);

    typedef struct packed {
        logic               valid;
        logic               pend;
        logic [LINE_AW-1:0] line;
        logic [LINE_W-1:0]  data;
    } slot_t;

    slot_t slot_q;

    assign catch_now = slot_q.pend && rsp_valid && (rsp_line == slot_q.line);
    assign hit_ready = slot_q.valid && (slot_q.line == probe_line);
    assign hit_wait  = slot_q.pend  && (slot_q.line == probe_line);
    assign held_data = slot_q.data;

    // priority: new allocation, then discard, then capture of a response
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (alloc) begin
            slot_q.valid <= 1'b0;
            slot_q.pend  <= 1'b1;
            slot_q.line  <= alloc_line;
        end else if (drop) begin
            slot_q.valid <= 1'b0;
            slot_q.pend  <= 1'b0;
        end else if (catch_now) begin
            slot_q.valid <= 1'b1;
            slot_q.pend  <= 1'b0;
            slot_q.data  <= rsp_data;
        end
    end

    // R4: the slot is never both waiting and full
    a_r4_slot_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(slot_q.valid && slot_q.pend));

    // R6: data only appears in a slot that was waiting for it
    a_r6_fill_after_wait: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_q.valid) |-> $past(slot_q.pend));

endmodule

// File: rtl/istream_ctrl.sv
module istream_ctrl
    import istream_pkg::*;
#(
    parameter int LINE_AW = DEF_LINE_AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    input  logic [LINE_AW-1:0] miss_line,
    output logic               miss_ready,
    output logic               req_valid,
    output logic [LINE_AW-1:0] req_line,
    input  logic               req_ready,
    input  logic               rsp_valid,
    input  logic [LINE_AW-1:0] rsp_line,
    input  logic               slot_hit_ready,
    input  logic               slot_hit_wait,
    input  logic               slot_catch,
    output logic               slot_alloc,
    output logic [LINE_AW-1:0] slot_alloc_line,
    output logic               slot_drop,
    output fill_src_e          fill_src,
    output logic [LINE_AW-1:0] fill_line
);

    isb_state_e         state_q, state_n;
    logic [LINE_AW-1:0] dem_q, dem_n;
    logic [LINE_AW-1:0] pf_q, pf_n;
    logic               dwait_q, dwait_n;
    logic               dem_rsp;

    assign dem_rsp    = dwait_q && rsp_valid && (rsp_line == dem_q);
    assign miss_ready = (state_q == ST_IDLE);

    always_comb begin
        state_n         = state_q;
        dem_n           = dem_q;
        pf_n            = pf_q;
        dwait_n         = dwait_q;
        req_valid       = 1'b0;
        req_line        = dem_q;
        slot_alloc      = 1'b0;
        slot_alloc_line = pf_q;
        slot_drop       = 1'b0;
        fill_src        = FSRC_NONE;
        fill_line       = dem_q;

        // demand response may land in any state while it is awaited
        if (dem_rsp) begin
            dwait_n  = 1'b0;
            fill_src = FSRC_RSP;
        end

        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid) begin
                    if (slot_hit_ready) begin
                        fill_src  = FSRC_BUF;
                        fill_line = miss_line;
                        slot_drop = 1'b1;
                        pf_n      = miss_line + 1'b1;
                        state_n   = ST_REQ_PF;
                    end else if (slot_hit_wait && slot_catch) begin
                        fill_src  = FSRC_RSP;
                        fill_line = miss_line;
                        slot_drop = 1'b1;
                        pf_n      = miss_line + 1'b1;
                        state_n   = ST_REQ_PF;
                    end else if (slot_hit_wait) begin
                        dem_n   = miss_line;
                        state_n = ST_WAIT_BUF;
                    end else begin
                        slot_drop = 1'b1;
                        dem_n     = miss_line;
                        dwait_n   = 1'b1;
                        pf_n      = miss_line + 1'b1;
                        state_n   = ST_REQ_DEM;
                    end
                end
            end
            ST_REQ_DEM: begin
                req_valid = 1'b1;
                req_line  = dem_q;
                if (req_ready) state_n = ST_REQ_PF;
            end
            ST_REQ_PF: begin
                req_valid = 1'b1;
                req_line  = pf_q;
                if (req_ready) begin
                    slot_alloc      = 1'b1;
                    slot_alloc_line = pf_q;
                    state_n         = dwait_n ? ST_WAIT_DEM : ST_IDLE;
                end
            end
            ST_WAIT_DEM: begin
                if (!dwait_n) state_n = ST_IDLE;
            end
            ST_WAIT_BUF: begin
                if (slot_catch) begin
                    fill_src  = FSRC_RSP;
                    fill_line = dem_q;
                    slot_drop = 1'b1;
                    pf_n      = dem_q + 1'b1;
                    state_n   = ST_REQ_PF;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dem_q   <= '0;
            pf_q    <= '0;
            dwait_q <= 1'b0;
        end else begin
            state_q <= state_n;
            dem_q   <= dem_n;
            pf_q    <= pf_n;
            dwait_q <= dwait_n;
        end
    end

    // R9: busy after a miss is taken
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> !miss_ready);

    // R10: an unanswered request holds its line
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

    // R2: the demand request is followed at once by its successor line
    a_r2_demand_then_next: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REQ_DEM && req_ready) |=>
            (req_valid && req_line == $past(req_line) + 1'b1));

endmodule

// File: rtl/istream_fill.sv
module istream_fill
    import istream_pkg::*;
#(
    parameter int LINE_AW = DEF_LINE_AW,
    parameter int LINE_W  = DEF_LINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  fill_src_e          src,
    input  logic [LINE_AW-1:0] line_in,
    input  logic [LINE_W-1:0]  buf_data,
    input  logic [LINE_W-1:0]  rsp_data,
    output logic               fill_valid,
    output logic [LINE_AW-1:0] fill_line,
    output logic [LINE_W-1:0]  fill_data
);

    logic [LINE_W-1:0] pick;

    always_comb begin
        unique case (src)
            FSRC_BUF: pick = buf_data;
            FSRC_RSP: pick = rsp_data;
            default:  pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_valid <= 1'b0;
            fill_line  <= '0;
            fill_data  <= '0;
        end else begin
            fill_valid <= (src != FSRC_NONE);
            if (src != FSRC_NONE) begin
                fill_line <= line_in;
                fill_data <= pick;
            end
        end
    end

endmodule

// File: rtl/istream_prefetch.sv
module istream_prefetch
    import istream_pkg::*;
#(
    parameter int LINE_AW = DEF_LINE_AW,
    parameter int LINE_W  = DEF_LINE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [LINE_AW-1:0] miss_line,
    output logic               fill_valid,
    output logic [LINE_AW-1:0] fill_line,
    output logic [LINE_W-1:0]  fill_data,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [LINE_AW-1:0] mem_req_line,
    input  logic               mem_rsp_valid,
    input  logic [LINE_AW-1:0] mem_rsp_line,
    input  logic [LINE_W-1:0]  mem_rsp_data
);

    logic               hit_ready, hit_wait, catch_now;
    logic [LINE_W-1:0]  held_data;
    logic               alloc, drop;
    logic [LINE_AW-1:0] alloc_line;
    fill_src_e          src;
    logic [LINE_AW-1:0] src_line;

    istream_entry #(.LINE_AW(LINE_AW), .LINE_W(LINE_W)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .probe_line (miss_line),
        .alloc      (alloc),
        .alloc_line (alloc_line),
        .drop       (drop),
        .rsp_valid  (mem_rsp_valid),
        .rsp_line   (mem_rsp_line),
        .rsp_data   (mem_rsp_data),
        .hit_ready  (hit_ready),
        .hit_wait   (hit_wait),
        .catch_now  (catch_now),
        .held_data  (held_data)
    );

    istream_ctrl #(.LINE_AW(LINE_AW)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .miss_valid      (miss_valid),
        .miss_line       (miss_line),
        .miss_ready      (miss_ready),
        .req_valid       (mem_req_valid),
        .req_line        (mem_req_line),
        .req_ready       (mem_req_ready),
        .rsp_valid       (mem_rsp_valid),
        .rsp_line        (mem_rsp_line),
        .slot_hit_ready  (hit_ready),
        .slot_hit_wait   (hit_wait),
        .slot_catch      (catch_now),
        .slot_alloc      (alloc),
        .slot_alloc_line (alloc_line),
        .slot_drop       (drop),
        .fill_src        (src),
        .fill_line       (src_line)
    );

    istream_fill #(.LINE_AW(LINE_AW), .LINE_W(LINE_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .line_in    (src_line),
        .buf_data   (held_data),
        .rsp_data   (mem_rsp_data),
        .fill_valid (fill_valid),
        .fill_line  (fill_line),
        .fill_data  (fill_data)
    );

    // R5: a miss on a stored line is filled from the slot next cycle
    a_r5_slot_fill: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready && hit_ready) |=>
            (fill_valid && fill_line == $past(miss_line) && fill_data == $past(held_data)));

endmodule

// File: tb/istream_prefetch_test.sv
module istream_prefetch_test;

    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NL = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          miss_valid = 1'b0;
    logic          miss_ready;
    logic [AW-1:0] miss_line = '0;
    logic          fill_valid;
    logic [AW-1:0] fill_line;
    logic [DW-1:0] fill_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_line;
    logic          mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_line = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    always #5 clk = ~clk;

    istream_prefetch #(.LINE_AW(AW), .LINE_W(DW)) uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line),
        .mem_rsp_data(mem_rsp_data)
    );

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] mdata(int l);
        return (DW'(l) * 32'h0101_0101) ^ 32'hA5C3_0F96;
    endfunction

    function automatic int nx(int x);
        return (x + 1) % NL;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // memory model and logs
    int lat = 1;
    int rpat = 0;
    int q_line [0:255];
    int q_due  [0:255];
    int q_head = 0, q_tail = 0, last_due = 0;
    int req_log [0:8191];
    int n_req = 0;
    int fl_line [0:8191];
    int fl_cyc  [0:8191];
    logic [DW-1:0] fl_data [0:8191];
    int n_fill = 0;
    int rsp_hist [0:63];
    bit prev_wait = 0;
    logic [AW-1:0] prev_line = '0;
    int hold_err = 0;
    bit ref_has = 0;
    int ref_line = 0;
    bit ref_arrived = 0;

    always @(negedge clk) begin
        if (fill_valid) begin
            fl_line[n_fill] = int'(fill_line);
            fl_data[n_fill] = fill_data;
            fl_cyc[n_fill]  = cyc;
            n_fill++;
        end
        if (prev_wait && !(mem_req_valid && mem_req_line == prev_line)) hold_err++;
        case (rpat)
            0:       mem_req_ready = 1'b1;
            1:       mem_req_ready = (cyc % 2) == 0;
            default: mem_req_ready = (cyc % 3) == 0;
        endcase
        prev_wait = mem_req_valid && !mem_req_ready;
        prev_line = mem_req_line;
        if (mem_req_valid && mem_req_ready) begin
            int due;
            req_log[n_req] = int'(mem_req_line);
            n_req++;
            due = cyc + lat;
            if (due <= last_due) due = last_due + 1;
            last_due = due;
            q_line[q_tail] = int'(mem_req_line);
            q_due[q_tail]  = due;
            q_tail = (q_tail + 1) % 256;
        end
        mem_rsp_valid = 1'b0;
        rsp_hist[cyc % 64] = -1;
        if (q_head != q_tail && q_due[q_head] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_line  = AW'(q_line[q_head]);
            mem_rsp_data  = mdata(q_line[q_head]);
            rsp_hist[cyc % 64] = q_line[q_head];
            if (ref_has && q_line[q_head] == ref_line) ref_arrived = 1;
            q_head = (q_head + 1) % 256;
        end
    end

    task automatic do_miss(int m);
        int fb, rb, acc, fc;
        bit exp_hit, arrived;
        string rq;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = AW'(m);
        while (!miss_ready) @(negedge clk);
        acc = cyc;
        exp_hit = ref_has && (ref_line == m);
        arrived = ref_arrived;
        fb = n_fill;
        rb = n_req;
        ref_has = 1;
        ref_line = nx(m);
        ref_arrived = 0;
        @(negedge clk);
        miss_valid = 1'b0;
        chk(miss_ready == 1'b0, "R9", "miss_ready after accept", int'(miss_ready), 0);
        while (!miss_ready) @(negedge clk);
        #2;
        rq = exp_hit ? (arrived ? "R5" : "R6") : "R3";
        chk(n_fill == fb + 1, rq, "fill count for miss", n_fill - fb, 1);
        if (n_fill > fb) begin
            fc = fl_cyc[fb];
            chk(fl_line[fb] == m, "R3", "fill line", fl_line[fb], m);
            chk(fl_data[fb] == mdata(m), "R3", "fill data", int'(fl_data[fb]), int'(mdata(m)));
            chk((fc == acc + 1) || (rsp_hist[(fc - 1) % 64] == m), rq,
                "fill cycle vs accept/response", fc, acc + 1);
            if (exp_hit && arrived)
                chk(fc == acc + 1, "R5", "slot fill latency", fc - acc, 1);
        end
        if (exp_hit) begin
            chk(n_req == rb + 1, rq, "requests on slot hit", n_req - rb, 1);
            if (n_req > rb)
                chk(req_log[rb] == nx(m), (m == NL - 1) ? "R8" : rq,
                    "prefetch line after hit", req_log[rb], nx(m));
        end else begin
            chk(n_req == rb + 2, "R2", "requests on miss", n_req - rb, 2);
            if (n_req >= rb + 2) begin
                chk(req_log[rb] == m, "R2", "demand line first", req_log[rb], m);
                chk(req_log[rb + 1] == nx(m), (m == NL - 1) ? "R8" : "R2",
                    "prefetch line second", req_log[rb + 1], nx(m));
            end
        end
    endtask

    task automatic run_scn(int b);
        int seq [0:14];
        int nf, nr;
        seq[0] = b;            seq[1] = nx(b);
        seq[2] = nx(nx(b));    seq[3] = nx(nx(nx(b)));
        seq[4] = seq[3];
        seq[5] = (b + 20) % NL; seq[6] = (b + 21) % NL;
        seq[7] = 62; seq[8] = 63; seq[9] = 0; seq[10] = 1;
        seq[11] = 30; seq[12] = 40; seq[13] = 31; seq[14] = 31;
        for (int i = 0; i < 15; i++) do_miss(seq[i]);
        nf = n_fill;
        nr = n_req;
        repeat (3 * lat + 20) @(negedge clk);
        #2;
        // R4: a late prefetch response alone makes no fill
        chk(n_fill == nf, "R4", "fills while idle", n_fill - nf, 0);
        chk(n_req == nr, "R7", "requests while idle", n_req - nr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(miss_ready == 1'b1, "R1", "miss_ready after reset", int'(miss_ready), 1);
        chk(fill_valid == 1'b0, "R1", "fill_valid after reset", int'(fill_valid), 0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", int'(mem_req_valid), 0);
        for (int l = 1; l <= 6; l++) begin
            for (int p = 0; p < 3; p++) begin
                lat = l;
                rpat = p;
                run_scn((l * 7 + p * 13) % NL);
            end
        end
        chk(hold_err == 0, "R10", "request hold violations", hold_err, 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule